// File: doc/BRIEF.md
# FIR-synapse neuron processing element

This block is a single neuron for a layered time-delay network in which every synaptic weight is replaced by a short FIR filter. All neurons of a layer see the same broadcast stream of signed 8-bit samples. Each neuron keeps its own tapped delay line of recent samples and a private coefficient ROM. For every accepted sample it computes a bias plus the convolution of the delay line with its coefficients, and then waits to place the result on the layer's shared output bus.

One multiplier is reused across all taps. A small sequencer accepts a sample, preloads the 18-bit accumulator from a bias register, and steps the ROM address through every tap, one multiply-accumulate per clock. When the last tap is done, the sum is copied into a holding register and the neuron raises a bus request. It drives the bus only during a cycle in which the bus grant is also present. The activation function sits beyond the shared bus and is not part of this block.

Top module: `fir_neuron_pe`

## Requirements
- R1: A reset, whenever it is applied, clears every delay-line stage to zero and leaves `bus_req`, `bus_oe` and `done` low and `bus_data` at zero.
- R2: A sample accepted at a clock edge becomes tap 0 (the newest). Every older sample moves one tap deeper, so tap k holds the sample accepted k samples earlier. The delay line changes only on acceptance.
- R3: Every computation starts from the bias value (parameter `BIAS`, default -300). With an all-zero delay line the result equals the bias exactly.
- R4: The coefficient for tap k is the low `COEF_W` bits of `COEF_BASE + k*COEF_STEP`, read as two's complement (defaults -100 and 37).
- R5: The delivered result is the bias plus the sum over k of coefficient k times tap k. It is accumulated in tap order k = 0 up to `TAPS`-1.
- R6: After each multiply-accumulate step, the running sum is clamped to the signed `ACC_W`-bit range, [-131072, 131071] by default, instead of wrapping.
- R7: If a sample is accepted at clock edge E0, `bus_req` is still low after edge E`TAPS`. `bus_req` and `done` are both high after edge E(`TAPS`+1), and `done` drops again at the following edge.
- R8: While `bus_req` is high and `bus_grant` is low, the held result does not change, `bus_oe` stays low and `bus_data` is zero.
- R9: In a cycle where `bus_req` and `bus_grant` are both high, `bus_oe` is high and `bus_data` carries the held result in that same cycle. At the next edge `bus_req` clears.
- R10: A `sample_valid` pulse that arrives while the neuron is computing or waiting for the bus is ignored. It affects neither the delay line nor any result.
- R11: `bus_grant` without a pending request leaves `bus_oe` low and `bus_data` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Broadcast sample present this cycle |
| sample_data | input | 8 | Broadcast sample, signed |
| bus_grant | input | 1 | Shared output bus granted to this neuron |
| bus_req | output | 1 | Result held and waiting for the bus |
| bus_oe | output | 1 | Neuron is driving the shared bus this cycle |
| bus_data | output | 18 | Held result while driving, otherwise zero, signed |
| done | output | 1 | One-cycle pulse when a new result is held |

## Verification
Several behaviours are checked on every cycle by the bound checker:
- the accumulator is preloaded with the bias and the newest tap is captured on each acceptance;
- the tap address advances by one per step;
- once the sum is clamped at a rail, it stays there against products that push it further;
- the held result stays stable while ungranted, and the request releases after a grant;
- off-sequence sample pulses leave the newest tap unchanged.

The numerical correctness of the convolution, the coefficient formula, the exact result latency and the clearing of history by a mid-computation reset can only be shown by the bench's scenarios. These compare delivered bus values against an independent FIR-plus-bias model, covering impulse, ramp and saturating sample sequences.

// File: rtl/fnpe_pkg.sv
package fnpe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_LOAD,
    ST_WAIT
  } fnpe_state_e;

  // Coefficient for tap k: low w bits of base + k*step, read as two's complement.
  function automatic int coef_value(int base, int step, int k, int w);
    int raw;
    int m;
    raw = base + k * step;
    m = raw & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  // Clamp a wide signed value into the signed w-bit range.
  function automatic longint clamp_signed(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/fnpe_delay_line.sv
module fnpe_delay_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 20
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           shift_en,
  input  logic [DATA_W-1:0]              din,
  output logic [TAPS-1:0][DATA_W-1:0]    taps_o
);

  logic [TAPS-1:0][DATA_W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q[0] <= '0;
    else if (shift_en) stage_q[0] <= din;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q[i] <= '0;
      else if (shift_en) stage_q[i] <= stage_q[i-1];
    end
  end

  assign taps_o = stage_q;

endmodule

// File: rtl/fnpe_coef_rom.sv
module fnpe_coef_rom #(
  parameter int COEF_W    = 8,
  parameter int TAPS      = 20,
  parameter int COEF_BASE = -100,
  parameter int COEF_STEP = 37,
  parameter int AW        = 5
) (
  input  logic [AW-1:0]            addr,
  output logic signed [COEF_W-1:0] coef
);
  import fnpe_pkg::*;

  logic [TAPS-1:0][COEF_W-1:0] rom;

  for (genvar k = 0; k < TAPS; k++) begin : g_word
    assign rom[k] = COEF_W'(coef_value(COEF_BASE, COEF_STEP, k, COEF_W));
  end

  assign coef = $signed(rom[addr]);

endmodule

// File: rtl/fnpe_ctrl.sv
module fnpe_ctrl #(
  parameter int TAPS = 20,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic          bus_grant,
  output logic          accept,
  output logic          step,
  output logic          last_step,
  output logic          hold_load,
  output logic          bus_req,
  output logic [AW-1:0] addr
);
  import fnpe_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

  fnpe_state_e   state_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (sample_valid) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) state_q <= ST_LOAD;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_LOAD: state_q <= ST_WAIT;
        ST_WAIT: if (bus_grant) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign accept    = (state_q == ST_IDLE) && sample_valid;
  assign step      = (state_q == ST_RUN);
  assign last_step = step && (cnt_q == LAST);
  assign hold_load = (state_q == ST_LOAD);
  assign bus_req   = (state_q == ST_WAIT);
  assign addr      = cnt_q;

endmodule

// File: rtl/fnpe_mac.sv
module fnpe_mac #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                preload,
  input  logic                                step,
  input  logic signed [ACC_W-1:0]             bias,
  input  logic signed [DATA_W-1:0]            tap,
  input  logic signed [COEF_W-1:0]            coef,
  output logic signed [ACC_W-1:0]             acc_o,
  output logic signed [DATA_W+COEF_W-1:0]     prod_o
);
  import fnpe_pkg::*;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;

  assign prod_o = tap * coef;

  always_comb begin
    acc_d = ACC_W'(clamp_signed(longint'(acc_q) + longint'(prod_o), ACC_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (preload) acc_q <= bias;
    else if (step)    acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/fir_neuron_pe.sv
module fir_neuron_pe #(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int ACC_W     = 18,
  parameter int TAPS      = 20,
  parameter int BIAS      = -300,
  parameter int COEF_BASE = -100,
  parameter int COEF_STEP = 37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_data,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              bus_oe,
  output logic [ACC_W-1:0]  bus_data,
  output logic              done
);

  localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int PW = DATA_W + COEF_W;

  logic                        accept;
  logic                        step;
  logic                        last_step;
  logic                        hold_load;
  logic [AW-1:0]               tap_addr;
  logic [TAPS-1:0][DATA_W-1:0] taps;
  logic signed [DATA_W-1:0]    tap_sel;
  logic [DATA_W-1:0]           newest_tap;
  logic signed [COEF_W-1:0]    coef;
  logic signed [PW-1:0]        prod;
  logic signed [ACC_W-1:0]     acc_q;
  logic signed [ACC_W-1:0]     bias_q;
  logic signed [ACC_W-1:0]     hold_q;
  logic                        done_q;

  fnpe_ctrl #(.TAPS(TAPS), .AW(AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .bus_grant    (bus_grant),
    .accept       (accept),
    .step         (step),
    .last_step    (last_step),
    .hold_load    (hold_load),
    .bus_req      (bus_req),
    .addr         (tap_addr)
  );

  fnpe_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (sample_data),
    .taps_o   (taps)
  );

  fnpe_coef_rom #(
    .COEF_W(COEF_W), .TAPS(TAPS), .COEF_BASE(COEF_BASE),
    .COEF_STEP(COEF_STEP), .AW(AW)
  ) u_rom (
    .addr (tap_addr),
    .coef (coef)
  );

  assign tap_sel    = $signed(taps[tap_addr]);
  assign newest_tap = taps[0];

  // Bias register: fixed value loaded at reset, kept for every preload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bias_q <= ACC_W'(BIAS);
  end

  fnpe_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .preload (accept),
    .step    (step),
    .bias    (bias_q),
    .tap     (tap_sel),
    .coef    (coef),
    .acc_o   (acc_q),
    .prod_o  (prod)
  );

  // Holding register waits for the shared bus.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (hold_load) hold_q <= acc_q;
      done_q <= hold_load;
    end
  end

  assign bus_oe   = bus_req & bus_grant;
  assign bus_data = bus_oe ? hold_q : '0;
  assign done     = done_q;

endmodule

// File: rtl/fnpe_checker.sv
module fnpe_checker #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18,
  parameter int AW     = 5,
  parameter int BIAS   = -300
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            sample_valid,
  input logic [DATA_W-1:0]               sample_data,
  input logic                            bus_grant,
  input logic                            bus_req,
  input logic                            done,
  input logic                            accept,
  input logic                            step,
  input logic                            last_step,
  input logic [AW-1:0]                   addr,
  input logic [DATA_W-1:0]               newest_tap,
  input logic signed [ACC_W-1:0]         acc,
  input logic signed [DATA_W+COEF_W-1:0] prod,
  input logic signed [ACC_W-1:0]         hold
);

  localparam logic signed [ACC_W-1:0] BIAS_V  = ACC_W'(BIAS);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  a_r2_newest_captured: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> newest_tap == $past(sample_data));

  a_r3_bias_preload: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> acc == BIAS_V);

  a_r5_tap_order: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last_step |=> addr == $past(addr) + 1'b1);

  a_r6_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    step && acc == ACC_MAX && prod >= 0 |=> acc == ACC_MAX);

  a_r6_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    step && acc == ACC_MIN && prod <= 0 |=> acc == ACC_MIN);

  a_r7_done_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bus_req);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_grant |=> bus_req && $stable(hold));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_grant |=> !bus_req);

  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !accept |=> $stable(newest_tap));

endmodule

bind fir_neuron_pe fnpe_checker #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .AW(AW), .BIAS(BIAS)
) u_fnpe_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .sample_data  (sample_data),
  .bus_grant    (bus_grant),
  .bus_req      (bus_req),
  .done         (done),
  .accept       (accept),
  .step         (step),
  .last_step    (last_step),
  .addr         (tap_addr),
  .newest_tap   (newest_tap),
  .acc          (acc_q),
  .prod         (prod),
  .hold         (hold_q)
);

// File: tb/fir_neuron_pe_bench.sv
module fir_neuron_pe_bench;

  localparam int TAPS   = 20;
  localparam int ACC_W  = 18;
  localparam int BIAS   = -300;
  localparam int CBASE  = -100;
  localparam int CSTEP  = 37;
  localparam int HI     = (1 << (ACC_W - 1)) - 1;
  localparam int LO     = -(1 << (ACC_W - 1));

  // Stimulus table: each row makes TAPS samples start + j*stride (wrapped to 8 bits).
  localparam int N_PAT = 4;
  localparam int PAT_START [N_PAT] = '{5, -90, 127, -3};
  localparam int PAT_STRIDE[N_PAT] = '{13, 29, -41, 7};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sample_valid = 1'b0;
  logic [7:0]       sample_data = '0;
  logic             bus_grant = 1'b0;
  logic             bus_req;
  logic             bus_oe;
  logic [ACC_W-1:0] bus_data;
  logic             done;

  int n_checks = 0;
  int n_fail   = 0;
  int hist [TAPS];

  always #2 clk = ~clk;

  fir_neuron_pe u_fir_neuron_pe (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .bus_grant    (bus_grant),
    .bus_req      (bus_req),
    .bus_oe       (bus_oe),
    .bus_data     (bus_data),
    .done         (done)
  );

  function automatic int wrap8(int v);
    int m;
    m = v & 255;
    if (m >= 128) m = m - 256;
    return m;
  endfunction

  function automatic int tap_coef(int k);
    return wrap8(CBASE + CSTEP * k);
  endfunction

  function automatic int model_sum();
    int s;
    s = BIAS;
    for (int k = 0; k < TAPS; k++) begin
      s = s + tap_coef(k) * hist[k];
      if (s > HI) s = HI;
      if (s < LO) s = LO;
    end
    return s;
  endfunction

  function automatic int bus_val();
    return int'($signed(bus_data));
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
  endtask

  // One full sample period: accept, latency, hold, grant, release.
  task automatic run_sample(input int x, input string tag, input bit busy_pulses);
    int exp;
    @(negedge clk);
    sample_valid = 1'b1;
    sample_data  = 8'(x);
    @(negedge clk);                       // after accepting edge E0
    sample_valid = 1'b0;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = wrap8(x);
    exp = model_sum();
    for (int j = 1; j <= TAPS; j++) begin
      if (busy_pulses && j == 3) begin sample_valid = 1'b1; sample_data = 8'(x ^ 8'h5a); end
      if (busy_pulses && j == 6) sample_valid = 1'b0;
      @(negedge clk);                     // after edge Ej
    end
    check("R7 no request before latency", int'(bus_req), 0);
    @(negedge clk);                       // after edge E(TAPS+1)
    check("R7 request raised", int'(bus_req), 1);
    check("R7 done pulse", int'(done), 1);
    check("R8 bus idle while ungranted", int'(bus_oe), 0);
    check("R8 bus data zero while ungranted", bus_val(), 0);
    if (busy_pulses) begin
      sample_valid = 1'b1;
      sample_data  = 8'(~x);
      repeat (3) @(negedge clk);
      check("R10 request kept while waiting", int'(bus_req), 1);
      check("R7 done dropped", int'(done), 0);
      sample_valid = 1'b0;
    end
    bus_grant = 1'b1;
    #1;
    check("R9 drive on grant", int'(bus_oe), 1);
    check(tag, bus_val(), exp);
    @(negedge clk);
    check("R9 request released", int'(bus_req), 0);
    check("R11 grant without request", int'(bus_oe), 0);
    check("R11 bus zero without request", bus_val(), 0);
    bus_grant = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    check("R1 reset bus_req", int'(bus_req), 0);
    check("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_grant = 1'b1;
    #1;
    check("R11 idle grant oe", int'(bus_oe), 0);
    check("R11 idle grant data", bus_val(), 0);
    @(negedge clk);
    bus_grant = 1'b0;

    // R3: zero sample on cleared line yields bias exactly
    run_sample(0, "R3 bias only", 1'b0);
    check("R3 model is bias", model_sum(), BIAS);

    // R4 and R2: impulse walks through every tap
    run_sample(1, "R4 coefficient tap 0", 1'b0);
    for (int k = 1; k < TAPS; k++) run_sample(0, $sformatf("R4 coefficient tap %0d", k), 1'b0);

    // R5: table of sample patterns
    for (int p = 0; p < N_PAT; p++)
      for (int j = 0; j < TAPS; j++)
        run_sample(wrap8(PAT_START[p] + j * PAT_STRIDE[p]), "R5 convolution sum", 1'b0);

    // R10: pulses while computing and waiting are ignored
    run_sample(-77, "R10 result unaffected", 1'b1);
    run_sample(44, "R10 history unaffected", 1'b0);

    // R6: positive then negative saturation
    for (int j = 0; j < TAPS; j++)
      run_sample((tap_coef(TAPS - 1 - j) >= 0) ? 127 : -128, "R6 clamp high path", 1'b0);
    check("R6 high rail", model_sum(), HI);
    for (int j = 0; j < TAPS; j++)
      run_sample((tap_coef(TAPS - 1 - j) >= 0) ? -128 : 127, "R6 clamp low path", 1'b0);
    check("R6 low rail", model_sum(), LO);

    // R1: reset during a computation clears history and state
    @(negedge clk);
    sample_valid = 1'b1;
    sample_data  = 8'd50;
    @(negedge clk);
    sample_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset req", int'(bus_req), 0);
    check("R1 mid-run reset done", int'(done), 0);
    rst_n = 1'b1;
    clear_model();
    run_sample(3, "R1 history cleared", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule